// File: doc/BRIEF.md
# Sticky Slot Enable Status Register

This block holds the set of transmit channel slots that an AC'97 link currently treats as active. Software cannot load the status word directly. It may only raise bits through a set port, where every 1 in the written word turns the matching status bit on, and drop bits through a clear port, where every 1 turns the matching bit off. Zero bits written to either port leave the status alone.

The codec may also ask for slots. The link's frame receiver extracts the codec's slot-request field and presents it here with a valid strobe. Each requested slot bit turns on and stays on until software clears it. This lets a driver remove slots that a codec requested before it was configured.

The status word is `NSLOTS` bits wide. Bit 0 stands for data slot 3 and bit `NSLOTS-1` for the highest data slot (slot 12 with the default of 10). Reads are combinational from a separate read address.

Top module: `slot_enable_status`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `slot_status` is all zeros.
- R2: A write to address 0 (the status address) leaves `slot_status` unchanged, whatever the written value.
- R3: A write to address 1 (the set port) turns on every status bit whose matching `wr_data` bit is 1, effective on the next clock edge. Bits written as 0 are unchanged.
- R4: A write to address 2 (the clear port) turns off every status bit whose matching `wr_data` bit is 1, effective on the next clock edge. Bits written as 0 are unchanged.
- R5: On a cycle with `req_valid` high, every 1 in `req_slots` turns on the matching status bit. The bit stays on through later cycles until a clear-port write removes it.
- R6: When `req_valid` is low, `req_slots` has no effect on the status.
- R7: A clear-port write and a codec request for the same bit in the same cycle leave that bit off, because the clear wins. A set-port write and a request in the same cycle give the union of both.
- R8: A read of address 0 returns the status zero-extended to `DW` bits. A read of address 1, 2 or 3 returns zero.
- R9: Status bit i stands for data slot i+3. `wr_data` bits at positions `NSLOTS` and above are ignored by every write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the register bus |
| wr_addr | input | AW | Write address: 0 status, 1 set port, 2 clear port |
| wr_data | input | DW | Write data |
| rd_addr | input | AW | Read address |
| rd_data | output | DW | Read data, combinational from `rd_addr` |
| req_valid | input | 1 | Codec slot-request valid strobe |
| req_slots | input | NSLOTS | Codec slot-request bits, bit 0 = slot 3 |
| slot_status | output | NSLOTS | Current sticky slot enable status |

## Verification
The bench builds the block with its default values: 10 slots, a 32-bit data bus and a 2-bit address. With these values every single bit position of the write word can be swept, including the 22 positions above the slot field that must be ignored. All four read addresses can also be covered. The small slot count means that a long pseudo-random run of mixed set, clear, status-write and request cycles touches every bit under each kind of collision. Expected values come from a bitwise model of set, request and clear.

// File: rtl/slot_enable_status.sv
module slot_enable_status #(
  parameter int NSLOTS = 10,
  parameter int DW     = 32,
  parameter int AW     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DW-1:0]     rd_data,
  input  logic              req_valid,
  input  logic [NSLOTS-1:0] req_slots,
  output logic [NSLOTS-1:0] slot_status
);
  localparam logic [AW-1:0] A_STAT = AW'(0);
  localparam logic [AW-1:0] A_SET  = AW'(1);
  localparam logic [AW-1:0] A_CLR  = AW'(2);

  logic [NSLOTS-1:0] set_m, clr_m, req_m, stat_q;

  assign set_m = (wr_en && wr_addr == A_SET) ? wr_data[NSLOTS-1:0] : '0;
  assign clr_m = (wr_en && wr_addr == A_CLR) ? wr_data[NSLOTS-1:0] : '0;
  assign req_m = req_valid ? req_slots : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q | set_m | req_m) & ~clr_m;
  end

  assign slot_status = stat_q;
  assign rd_data     = (rd_addr == A_STAT) ? DW'(stat_q) : '0;

  p_reset_zero_r1: assert property (@(posedge clk)
    !rst_n |=> slot_status == '0);

  p_status_write_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_STAT && !req_valid) |=> $stable(slot_status));

  p_set_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_SET) |=>
      (slot_status & $past(wr_data[NSLOTS-1:0])) == $past(wr_data[NSLOTS-1:0]));

  p_clear_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_CLR) |=>
      (slot_status & $past(wr_data[NSLOTS-1:0])) == '0);

  p_request_sticks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == A_CLR) |=>
      (slot_status & $past(slot_status)) == $past(slot_status));

  p_no_spurious_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (slot_status & ~$past(slot_status) &
              ~($past(req_valid) ? $past(req_slots) : '0) &
              ~(($past(wr_en) && $past(wr_addr) == A_SET) ? $past(wr_data[NSLOTS-1:0]) : '0)) == '0);

  p_read_ports_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr != A_STAT) |-> rd_data == '0);
endmodule

// File: tb/slot_enable_status_bench.sv
`timescale 1ns/1ps
module slot_enable_status_bench;
  localparam int N = 10;
  localparam int DW = 32;
  localparam int AW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic req_valid = 1'b0;
  logic [N-1:0] req_slots = '0;
  logic [N-1:0] slot_status;

  int checks = 0;
  int errors = 0;
  logic [N-1:0] model = '0;
  logic [31:0] lfsr = 32'h1ACE_B00C;
  bit finished = 0;

  always #2.5 clk = ~clk;

  slot_enable_status #(.NSLOTS(N), .DW(DW), .AW(AW)) u_slot_enable_status (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .req_valid(req_valid),
    .req_slots(req_slots), .slot_status(slot_status));

  task automatic check(input string tag);
    checks++;
    if (slot_status !== model) begin
      errors++;
      $display("FAIL %s: slot_status=%h expected %h", tag, slot_status, model);
    end
    checks++;
    if (rd_data !== DW'(model)) begin
      errors++;
      $display("FAIL %s: rd_data=%h expected %h", tag, rd_data, DW'(model));
    end
  endtask

  // kind: 0 idle, 1 write status addr, 2 set, 3 clear
  task automatic step(input int kind, input logic [DW-1:0] d,
                      input logic rv, input logic [N-1:0] rs, input string tag);
    logic [N-1:0] s, c, q;
    wr_en     = (kind != 0);
    wr_addr   = (kind == 2) ? AW'(1) : (kind == 3) ? AW'(2) : AW'(0);
    wr_data   = d;
    req_valid = rv;
    req_slots = rs;
    s = (kind == 2) ? d[N-1:0] : '0;
    c = (kind == 3) ? d[N-1:0] : '0;
    q = rv ? rs : '0;
    model = (model | s | q) & ~c;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0; wr_data = '0; req_slots = '0;
    #0.5;
    check(tag);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not end, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 during reset");
    rst_n = 1'b1;
    @(negedge clk); #0.5;
    check("R1 after reset");

    // R3 / R9: single-bit sweep over every data bit
    for (int i = 0; i < DW; i++)
      step(2, DW'(1) << i, 1'b0, '0, (i < N) ? "R3 set bit" : "R9 upper bit ignored");
    // R2: status-address write has no effect
    step(1, '0, 1'b0, '0, "R2 write zero to status");
    // R4: clear each bit in turn
    for (int i = 0; i < DW; i++)
      step(3, DW'(1) << i, 1'b0, '0, (i < N) ? "R4 clear bit" : "R9 upper clear ignored");
    step(1, '1, 1'b0, '0, "R2 write ones to status");

    // R5: requests are sticky
    step(0, '0, 1'b1, 10'h005, "R5 request");
    step(0, '0, 1'b1, 10'h000, "R5 empty request");
    for (int i = 0; i < 4; i++) step(0, '0, 1'b0, '0, "R5 sticky idle");
    step(3, 32'h1, 1'b0, '0, "R5 cleared by software");

    // R6: slots ignored without valid
    step(0, '0, 1'b0, '1, "R6 no valid");
    step(1, 32'h3FF, 1'b0, '1, "R6 no valid with status write");

    // R7: collisions
    step(2, 32'h0F0, 1'b0, '0, "R7 prep");
    step(3, 32'h0F0, 1'b1, 10'h0F0, "R7 clear beats request");
    step(2, 32'h00F, 1'b1, 10'h300, "R7 set and request union");
    step(2, 32'h030, 1'b1, 10'h030, "R7 set and request same bits");

    // R8: read port addresses
    for (int a = 1; a < 4; a++) begin
      rd_addr = AW'(a);
      #0.5;
      checks++;
      if (rd_data !== '0) begin
        errors++;
        $display("FAIL R8 addr %0d: rd_data=%h expected 0", a, rd_data);
      end
    end
    rd_addr = '0;
    #0.5;

    // mixed pseudo-random run
    for (int n = 0; n < 3000; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step(int'(lfsr[1:0]), {lfsr[15:0], lfsr[31:16]}, lfsr[7],
           lfsr[29:20] & lfsr[19:10], "R7 mixed run");
    end

    // R1: reset from a loaded state
    step(2, '1, 1'b0, '0, "R1 preload");
    rst_n = 1'b0;
    model = '0;
    @(posedge clk); @(negedge clk); #0.5;
    check("R1 reset from loaded");
    rst_n = 1'b1;

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule